// File: doc/BRIEF.md
# SPI Chip-Select Timing Sequencer

This block wraps every SPI transaction in a programmable timing envelope. On a start request it pulls one of two active-low chip selects, waits a setup interval before the serial clock starts, lets the clock run until the shift engine reports that its last bit edge is done, then holds the line for the last data and waits again before releasing the select. After release it keeps both selects high for a minimum deselect interval before it accepts the next request. All four intervals are counted in reference clock cycles. They come from one 32-bit timing word, which is held inside the block and loaded through a write strobe.

While the clock runs, the block produces the serial clock itself, divided down from the reference clock. It also produces one-cycle pulses on the leading and trailing edge of each clock period, so that a separate shift register can launch and capture data. The period comes from an 8-bit base divider. When the second chip select is chosen and the override is enabled, a 16-bit divider is used in its place. The select and the period are latched when a request is accepted. The clock idle level follows `cpol`, and the clock rests at that level in every phase except the running phase.

The state machine has six states:
- `ST_IDLE`: waiting for a request. When `start` is high with a valid select, the machine goes to `ST_LEAD`.
- `ST_LEAD`: select asserted, clock idle. When the setup count expires, the machine goes to `ST_RUN`.
- `ST_RUN`: clock toggling. When `last_done` is seen, the machine goes to `ST_HOLD`.
- `ST_HOLD`: data hold, clock idle. When the hold count expires, the machine goes to `ST_TAIL`.
- `ST_TAIL`: clock stopped, select still asserted. When the release count expires, the machine goes to `ST_GAP`.
- `ST_GAP`: both selects high. When the deselect count expires, the machine returns to `ST_IDLE`.

Top module: `spi_cs_sequencer`

## Requirements
- R1: After reset both `cs_n` bits are 1, `sck` equals `cpol`, and no edge pulse is present. The timing word resets to 0x06060406, so the first transaction shows 7 cycles of asserted select before the first leading edge.
- R2: In `ST_IDLE`, `start` with `cs_sel` equal to 0 or 1 drives `cs_n[cs_sel]` low on the next cycle while the other bit stays high. `start` with `cs_sel` equal to 2 or 3 is ignored, and `cs_n` stays 2'b11.
- R3: The setup phase lasts (timing bits 3:0)+1 cycles. During it the select is low and `sck` is at its idle level.
- R4: While running, the `sck` period is P reference cycles. Here P is `base_div`, except that 0 means 256 and 1 means 2. The first P/2 cycles (P/2 rounded down) are at the active level, which is not `cpol`, and the rest are at the idle level. `sck_lead` pulses in the first cycle of each period and `sck_trail` pulses in cycle P/2.
- R5: If `cs_sel`=1 and `alt_div_en`=1 when a request is accepted, P comes from `alt_div` instead, where 0 means 65536 and 1 means 2. Select 0 always uses `base_div`.
- R6: `last_done` sampled in `ST_RUN` returns `sck` to idle on the next cycle. The select then stays low for (timing bits 19:16)+1 hold cycles.
- R7: After the hold, the select stays low for a further (timing bits 11:8)+1 cycles before it goes high.
- R8: After release, both selects stay high for (timing bits 31:24)+1 cycles, and `start` has no effect during that time. With `start` already high, the next select asserts one idle cycle later.
- R9: With `cpol`=1 the clock idles high and its active half is low.
- R10: Timing word bits 7:4, 15:12 and 23:20 are not stored and have no effect on any interval.
- R11: At no time is more than one `cs_n` bit low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| tim_we | input | 1 | Load strobe for the timing word |
| tim_wdata | input | 32 | Timing word: setup 3:0, release 11:8, hold 19:16, deselect 31:24 |
| cpol | input | 1 | Serial clock idle level |
| cs_sel | input | 2 | Requested chip select (0 or 1 valid) |
| base_div | input | BASE_DIV_W | Base clock divider |
| alt_div | input | ALT_DIV_W | Override divider for select 1 |
| alt_div_en | input | 1 | Enables the select-1 override |
| start | input | 1 | Transaction request, held until the select asserts |
| last_done | input | 1 | Shift engine has finished its last edge |
| cs_n | output | 2 | Active-low chip selects |
| sck | output | 1 | Serial clock |
| sck_lead | output | 1 | Pulse in the first cycle of each clock period |
| sck_trail | output | 1 | Pulse at the mid-period edge |

## Verification
The hardest situation to reach is a request that arrives during the minimum deselect interval of the previous transaction. It only happens when a second request follows a release almost immediately. The bench issues two transactions back to back, raising `start` for the second one in the cycle after the first select goes high with a non-zero deselect count. It then measures the high gap against the count, while a behavioural model checks every cycle. The override divider and the zero-interval corner are reached by reprogramming the timing word between transactions. The zero-interval load carries ones in every unused bit.

// File: rtl/spi_cs_seq_pkg.sv
package spi_cs_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LEAD = 3'd1,
        ST_RUN  = 3'd2,
        ST_HOLD = 3'd3,
        ST_TAIL = 3'd4,
        ST_GAP  = 3'd5
    } seq_state_t;

    typedef struct packed {
        logic [7:0] gap;
        logic [3:0] hold;
        logic [3:0] tail;
        logic [3:0] lead;
    } dly_set_t;

    localparam logic [31:0] TIM_RST_WORD = 32'h0606_0406;

    function automatic dly_set_t unpack_dly(input logic [31:0] w);
        dly_set_t d;
        d.lead = w[3:0];
        d.tail = w[11:8];
        d.hold = w[19:16];
        d.gap  = w[31:24];
        return d;
    endfunction

endpackage

// File: rtl/scs_timing_reg.sv
module scs_timing_reg
    import spi_cs_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output dly_set_t    dly
);

    dly_set_t dly_q;
    logic     unused_rsvd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q <= unpack_dly(TIM_RST_WORD);
        end else if (we) begin
            dly_q <= unpack_dly(wdata);
        end
    end

    // bits outside the four fields are dropped on load
    assign unused_rsvd = ^{wdata[7:4], wdata[15:12], wdata[23:20]};
    assign dly = dly_q;

endmodule

// File: rtl/scs_period_sel.sv
module scs_period_sel #(
    parameter int BASE_W = 8,
    parameter int ALT_W  = 16,
    parameter int PER_W  = 17
) (
    input  logic [BASE_W-1:0] base_div,
    input  logic [ALT_W-1:0]  alt_div,
    input  logic              alt_en,
    input  logic              sel_one,
    output logic [PER_W-1:0]  period
);

    localparam logic [PER_W-1:0] BASE_FULL = PER_W'(1) << BASE_W;
    localparam logic [PER_W-1:0] ALT_FULL  = PER_W'(1) << ALT_W;
    localparam logic [PER_W-1:0] MIN_PER   = PER_W'(2);

    logic [PER_W-1:0] base_p;
    logic [PER_W-1:0] alt_p;
    logic [PER_W-1:0] chosen;

    always_comb begin
        base_p = (base_div == '0) ? BASE_FULL : PER_W'(base_div);
        alt_p  = (alt_div  == '0) ? ALT_FULL  : PER_W'(alt_div);
        chosen = (sel_one && alt_en) ? alt_p : base_p;
        period = (chosen < MIN_PER) ? MIN_PER : chosen;
    end

endmodule

// File: rtl/scs_sck_gen.sv
module scs_sck_gen #(
    parameter int PER_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cpol,
    input  logic [PER_W-1:0] period,
    output logic             sck,
    output logic             lead,
    output logic             trail
);

    logic [PER_W-1:0] pc;
    logic [PER_W-1:0] half;

    assign half = period >> 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (!run || pc == period - PER_W'(1)) begin
            pc <= '0;
        end else begin
            pc <= pc + PER_W'(1);
        end
    end

    assign sck   = cpol ^ (run && (pc < half));
    assign lead  = run && (pc == '0);
    assign trail = run && (pc == half);

endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer
    import spi_cs_seq_pkg::*;
#(
    parameter int BASE_DIV_W = 8,
    parameter int ALT_DIV_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tim_we,
    input  logic [31:0]           tim_wdata,
    input  logic                  cpol,
    input  logic [1:0]            cs_sel,
    input  logic [BASE_DIV_W-1:0] base_div,
    input  logic [ALT_DIV_W-1:0]  alt_div,
    input  logic                  alt_div_en,
    input  logic                  start,
    input  logic                  last_done,
    output logic [1:0]            cs_n,
    output logic                  sck,
    output logic                  sck_lead,
    output logic                  sck_trail
);

    localparam int PER_W  = ((BASE_DIV_W > ALT_DIV_W) ? BASE_DIV_W : ALT_DIV_W) + 1;
    localparam int NUM_CS = 2;
    localparam int CNT_W  = 8;

    seq_state_t       state;
    seq_state_t       nxt;
    logic [CNT_W-1:0] cnt;
    dly_set_t         dly;
    logic [PER_W-1:0] period_w;
    logic [PER_W-1:0] per_q;
    logic             sel_q;
    logic             accept;

    scs_timing_reg u_tim (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tim_we),
        .wdata (tim_wdata),
        .dly   (dly)
    );

    scs_period_sel #(
        .BASE_W (BASE_DIV_W),
        .ALT_W  (ALT_DIV_W),
        .PER_W  (PER_W)
    ) u_per (
        .base_div (base_div),
        .alt_div  (alt_div),
        .alt_en   (alt_div_en),
        .sel_one  (cs_sel == 2'd1),
        .period   (period_w)
    );

    scs_sck_gen #(
        .PER_W (PER_W)
    ) u_sck (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_RUN),
        .cpol   (cpol),
        .period (per_q),
        .sck    (sck),
        .lead   (sck_lead),
        .trail  (sck_trail)
    );

    assign accept = (state == ST_IDLE) && start && (cs_sel < 2'(NUM_CS));

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept)                       nxt = ST_LEAD;
            ST_LEAD: if (cnt == CNT_W'(dly.lead))      nxt = ST_RUN;
            ST_RUN:  if (last_done)                    nxt = ST_HOLD;
            ST_HOLD: if (cnt == CNT_W'(dly.hold))      nxt = ST_TAIL;
            ST_TAIL: if (cnt == CNT_W'(dly.tail))      nxt = ST_GAP;
            ST_GAP:  if (cnt == dly.gap)               nxt = ST_IDLE;
            default:                                   nxt = ST_IDLE;
        endcase
    end

    // state register, phase counter and per-transaction latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            sel_q <= 1'b0;
            per_q <= PER_W'(2);
        end else begin
            state <= nxt;
            cnt   <= (nxt != state) ? '0 : cnt + CNT_W'(1);
            if (accept) begin
                sel_q <= cs_sel[0];
                per_q <= period_w;
            end
        end
    end

    // select outputs
    always_comb begin
        cs_n = '1;
        unique case (state)
            ST_LEAD, ST_RUN, ST_HOLD, ST_TAIL: cs_n[sel_q] = 1'b0;
            default: ;
        endcase
    end

endmodule

// File: rtl/spi_cs_sequencer_checker.sv
module spi_cs_sequencer_checker
    import spi_cs_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cpol,
    input logic [1:0] cs_sel,
    input logic       start,
    input logic       last_done,
    input logic [1:0] cs_n,
    input logic       sck,
    input logic       sck_lead,
    input logic       sck_trail,
    input seq_state_t state
);

    p_one_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    p_bad_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && cs_sel[1]) |=> (cs_n == 2'b11));

    p_setup_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD) |-> (sck == cpol && cs_n != 2'b11));

    p_lead_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sck_lead |-> (sck != cpol));

    p_trail_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sck_trail |-> (sck == cpol));

    p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && last_done) |=> (sck == cpol && !sck_lead && cs_n != 2'b11));

    p_tail_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL) |=> (state == ST_TAIL || state == ST_GAP));

    p_gap_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> (cs_n == 2'b11));

    p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n == 2'b11) |-> (sck == cpol));

endmodule

bind spi_cs_sequencer spi_cs_sequencer_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpol      (cpol),
    .cs_sel    (cs_sel),
    .start     (start),
    .last_done (last_done),
    .cs_n      (cs_n),
    .sck       (sck),
    .sck_lead  (sck_lead),
    .sck_trail (sck_trail),
    .state     (state)
);

// File: tb/spi_cs_sequencer_tb.sv
`timescale 1ns/1ps
module spi_cs_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tim_we = 1'b0;
    logic [31:0] tim_wdata = '0;
    logic        cpol = 1'b0;
    logic [1:0]  cs_sel = 2'd0;
    logic [7:0]  base_div = 8'd4;
    logic [15:0] alt_div = 16'd0;
    logic        alt_div_en = 1'b0;
    logic        start = 1'b0;
    logic        last_done = 1'b0;
    logic [1:0]  cs_n;
    logic        sck, sck_lead, sck_trail;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string tag_force = "";

    always #2 clk = ~clk;   // 250 MHz

    spi_cs_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .tim_we(tim_we), .tim_wdata(tim_wdata),
        .cpol(cpol), .cs_sel(cs_sel), .base_div(base_div), .alt_div(alt_div),
        .alt_div_en(alt_div_en), .start(start), .last_done(last_done),
        .cs_n(cs_n), .sck(sck), .sck_lead(sck_lead), .sck_trail(sck_trail)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", rq, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          mst, rem, ph, per, msel;
    bit          m_alt;
    logic [31:0] tw;

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; rem = 0; ph = 0; per = 2; msel = 0; m_alt = 0;
            tw = 32'h0606_0406;
        end else begin
            case (mst)
                0: if (start && cs_sel < 2) begin
                       msel  = cs_sel[0];
                       m_alt = alt_div_en;
                       if (cs_sel == 1 && alt_div_en)
                           per = (alt_div == 0) ? 65536 : ((alt_div == 1) ? 2 : alt_div);
                       else
                           per = (base_div == 0) ? 256 : ((base_div == 1) ? 2 : base_div);
                       mst = 1; rem = tw[3:0]; ph = 0;
                   end
                1: if (rem == 0) begin mst = 2; ph = 0; end else rem--;
                2: if (last_done) begin mst = 3; rem = tw[19:16]; end
                   else ph = (ph + 1) % per;
                3: if (rem == 0) begin mst = 4; rem = tw[11:8]; end else rem--;
                4: if (rem == 0) begin mst = 5; rem = tw[31:24]; end else rem--;
                default: if (rem == 0) mst = 0; else rem--;
            endcase
            if (tim_we) tw = tim_wdata;
        end
    end

    function automatic string phase_tag();
        if (tag_force != "") return tag_force;
        case (mst)
            0: return "R2";
            1: return "R3";
            2: return cpol ? "R9" : (m_alt ? "R5" : "R4");
            3: return "R6";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    // every-cycle comparison, away from the active edge (R11 covered by exp_cs)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [1:0] exp_cs;
            logic [4:0] e, a;
            exp_cs = 2'b11;
            if (mst >= 1 && mst <= 4) exp_cs[msel] = 1'b0;
            e = {exp_cs, cpol ^ (mst == 2 && ph < per / 2),
                 (mst == 2 && ph == 0), (mst == 2 && ph == per / 2)};
            a = {cs_n, sck, sck_lead, sck_trail};
            chk(a == e, phase_tag(), 32'(a), 32'(e));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_tim(input logic [31:0] v);
        @(posedge clk); #1; tim_we = 1'b1; tim_wdata = v;
        @(posedge clk); #1; tim_we = 1'b0;
    endtask

    // gapc: high negedges before select asserts; setc: low negedges before first lead
    task automatic run_txn(input bit sel, input int ntr, output int gapc, output int setc);
        int n;
        @(posedge clk); #1; cs_sel = {1'b0, sel}; start = 1'b1;
        gapc = 0;
        forever begin
            @(negedge clk);
            if (cs_n != 2'b11) break;
            gapc++;
        end
        start = 1'b0;
        setc = 0;
        while (!sck_lead) begin setc++; @(negedge clk); end
        n = 0;
        while (n < ntr) begin @(negedge clk); if (sck_trail) n++; end
        @(posedge clk); #1; last_done = 1'b1;
        @(posedge clk); #1; last_done = 1'b0;
        forever begin @(negedge clk); if (cs_n == 2'b11) break; end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int g, s, g2, s2;
        bit ok;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk({cs_n, sck, sck_lead, sck_trail} == 5'b11000, "R1",
            32'({cs_n, sck, sck_lead, sck_trail}), 32'b11000);

        // R1: default timing word gives 6+1 setup cycles
        run_txn(1'b0, 3, g, s);
        chk(s == 7, "R1", s, 7);
        settle(40);

        // R2: invalid select values are ignored
        @(posedge clk); #1; cs_sel = 2'd2; start = 1'b1;
        ok = 1'b1;
        repeat (10) begin @(negedge clk); if (cs_n != 2'b11) ok = 1'b0; end
        @(posedge clk); #1; cs_sel = 2'd3;
        repeat (10) begin @(negedge clk); if (cs_n != 2'b11) ok = 1'b0; end
        chk(ok, "R2", 32'(cs_n), 32'b11);
        @(posedge clk); #1; start = 1'b0; cs_sel = 2'd0;

        // R3 / R6 / R7: reprogrammed intervals, odd base divider on select 1
        wr_tim(32'h0103_0201);
        base_div = 8'd5;
        run_txn(1'b1, 2, g, s);
        chk(s == 2, "R3", s, 2);
        settle(20);

        // R5: override divider on select 1, ignored for select 0
        base_div = 8'd4; alt_div = 16'd3; alt_div_en = 1'b1;
        run_txn(1'b1, 3, g, s);
        settle(20);
        run_txn(1'b0, 2, g, s);
        settle(20);
        alt_div = 16'd1;
        run_txn(1'b1, 2, g, s);
        settle(20);
        alt_div_en = 1'b0;

        // R4: divider value 1 clamps to 2, value 0 means 256
        base_div = 8'd1;
        run_txn(1'b0, 3, g, s);
        settle(20);
        base_div = 8'd0;
        run_txn(1'b1, 2, g, s);
        settle(20);

        // R9: idle-high clock
        @(posedge clk); #1; cpol = 1'b1; base_div = 8'd6;
        run_txn(1'b1, 2, g, s);
        settle(20);
        @(posedge clk); #1; cpol = 1'b0;

        // R8: request waiting through the deselect interval (gap field 9)
        wr_tim(32'h0902_0103);
        base_div = 8'd3;
        run_txn(1'b0, 2, g, s);
        run_txn(1'b1, 1, g2, s2);
        chk(g2 == 10, "R8", g2, 10);
        chk(s2 == 4, "R3", s2, 4);
        settle(20);

        // R10: unused bits set, all intervals zero
        tag_force = "R10";
        wr_tim(32'h00F0_F0F0);
        run_txn(1'b0, 2, g, s);
        chk(s == 1, "R10", s, 1);
        run_txn(1'b1, 1, g2, s2);
        chk(g2 == 1, "R10", g2, 1);
        settle(10);
        tag_force = "";

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule